// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Port

This block is a slave-side control port that holds a small bank of 8-bit configuration registers and drives every register bit out in parallel to the logic around it. A fast system clock oversamples the serial clock, the serial data line and one shared pin. That pin serves as the low address bit while the port runs as an I2C target, and as the active-low chip select once the port runs as a write-only SPI-style target.

The port leaves reset as an I2C target that can both read and write. The first falling edge on the shared pin switches it to SPI operation, and it stays there until the next reset. Both modes write a pointer byte first. Its top bit enables auto-increment and its low three bits pick a register. Data bytes then go to the register the pointer selects, or come from it.

Top module: `cfgport_top`

## Requirements
- R1: After a synchronous active-low reset, the registers hold 0x00, 0x83, 0x49, 0x00 and 0x00 at indices 0 to 4. The port is in I2C mode, the pointer is index 0 with increment off, and the data line is not driven.
- R2: In I2C mode, the port acknowledges an address byte whose upper seven bits equal 001000 followed by the sampled level of the shared pin. The least significant bit selects the direction: 1 means read. The port also acknowledges every written byte that follows.
- R3: If the address does not match, the port leaves the acknowledge bit released and ignores the bus until the next START. No register changes.
- R4: The first byte written after the address is the pointer byte. Bit 7 is the increment enable, bits 2:0 are the register index, and bits 6:3 are ignored.
- R5: With increment set, the index advances by one after every data byte written or read, and wraps modulo 8. With increment clear, the index stays fixed, so repeated writes land on the same register.
- R6: An I2C read returns the register at the current index, MSB first, with each bit changed while the clock is low. The port keeps sending successive bytes while the master acknowledges, and stops after a not-acknowledge. A read that has no pointer write before it uses the last pointer written, or index 0 after reset.
- R7: Indices 5 to 7 exist only as pointer values. Writes to them are acknowledged and discarded, and reads from them return 0x00.
- R8: The first high-to-low transition of the shared pin after reset sets SPI mode permanently. Later levels on the pin do not return the port to I2C mode.
- R9: In SPI mode, data is sampled on the rising serial clock edge while the chip select is low, MSB first. The first byte must be 0x20, the second is the pointer byte, and the rest are data. Raising the chip select ends the transfer. A transfer whose first byte is not 0x20 changes nothing.
- R10: In SPI mode, I2C traffic is ignored: no acknowledge is driven and no register changes.
- R11: Register k appears on bits [8k+7:8k] of the parallel configuration output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock (I2C clock, or SPI clock in SPI mode) |
| sda_i | input | 1 | Serial data line as seen on the pin (SPI data in SPI mode) |
| sel_i | input | 1 | Shared pin: address bit in I2C mode, active-low chip select in SPI mode |
| sda_oe_o | output | 1 | Pull the data line low when 1 (open-drain drive) |
| spi_mode_o | output | 1 | 1 once SPI mode has been selected |
| cfg_o | output | 8*NREG | Parallel image of all configuration registers |

## Verification
A corrupted pointer appears at the ports on the very next data byte. A block write then fills the wrong slice of `cfg_o` as soon as that byte's acknowledge is driven. A read returns the wrong value within the same byte time. A wrong bit count or address compare shows up as a missing or misplaced acknowledge on the ninth clock of the address byte. A mode flag that is lost or set too early is seen within one transfer: I2C traffic is either acknowledged when it must not be, or an SPI write leaves `cfg_o` untouched.

// File: rtl/ctlport_pkg.sv
// Shared constants and types for the dual-mode configuration port.
package ctlport_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned INCR_BIT = 7;
    localparam logic [5:0]  I2C_ADDR_HI   = 6'b001000;
    localparam logic [7:0]  SPI_ADDR_BYTE = 8'h20;

    // Pointer state: increment flag plus register index.
    typedef struct packed {
        logic             incr;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    // Reset value of register k.
    function automatic logic [BYTE_W-1:0] reg_reset_val(input int unsigned k);
        case (k)
            1:       return 8'h83;
            2:       return 8'h49;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ctlport_sync.sv
// Multi-bit synchronizer. Gives the synchronized level and the level one
// clock earlier, so the parent can detect edges.
// Assumes the inputs change slowly compared with clk. There is no glitch filter.
module ctlport_sync #(
    parameter int unsigned W        = 3,
    parameter int unsigned STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] dly_o
);
    logic [STAGES:0][W-1:0] stage_q;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= {(STAGES+1){RST_VAL}};
        else        stage_q <= {stage_q[STAGES-1:0], d_i};
    end

    assign lvl_o = stage_q[STAGES-1];
    assign dly_o = stage_q[STAGES];
endmodule

// File: rtl/ctlport_regs.sv
// Configuration register bank and address pointer.
// Assumes that at most one of ptr_we, data_we and rd_adv is high in a cycle.
module ctlport_regs
    import ctlport_pkg::*;
#(
    parameter int unsigned NREG = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ptr_we_i,
    input  logic                   data_we_i,
    input  logic                   rd_adv_i,
    input  logic [BYTE_W-1:0]      wr_byte_i,
    output logic [BYTE_W-1:0]      rd_byte_o,
    output logic [NREG*BYTE_W-1:0] bank_o
);
    localparam logic [IDX_W:0] NREG_L = (IDX_W+1)'(NREG);

    ptr_t ptr_q;
    logic hit_w;

    assign hit_w = {1'b0, ptr_q.idx} < NREG_L;

    // Load the pointer, or advance it after a data byte when increment is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_we_i)
            ptr_q <= '{incr: wr_byte_i[INCR_BIT], idx: wr_byte_i[IDX_W-1:0]};
        else if ((data_we_i || rd_adv_i) && ptr_q.incr)
            ptr_q.idx <= ptr_q.idx + 1'b1;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic [BYTE_W-1:0] r_q;
        // Capture a data byte aimed at this register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= reg_reset_val(k);
            else if (data_we_i && ptr_q.idx == IDX_W'(k))
                r_q <= wr_byte_i;
        end
        assign bank_o[k*BYTE_W +: BYTE_W] = r_q;
    end

    // Select the register at the pointer. Unbacked indices read as zero.
    always_comb begin
        rd_byte_o = '0;
        for (int k = 0; k < NREG; k++)
            if (ptr_q.idx == IDX_W'(k)) rd_byte_o = bank_o[k*BYTE_W +: BYTE_W];
    end

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we_i && !ptr_q.incr && !ptr_we_i) |=> $stable(ptr_q));

    // R7
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we_i && !hit_w) |=> $stable(bank_o));
endmodule

// File: rtl/ctlport_i2c.sv
// I2C target engine working on oversampled SCL and SDA.
// Samples data on SCL rising edges and changes SDA only after SCL falling
// edges. While en_i is low the engine is held idle and releases SDA.
module ctlport_i2c
    import ctlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              scl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    input  logic              ad0_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              sda_oe_o,
    output logic              ptr_we_o,
    output logic              data_we_o,
    output logic              rd_adv_o,
    output logic [BYTE_W-1:0] wr_byte_o
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_SKIP
    } st_e;

    st_e               st_q;
    logic [3:0]        cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              rw_q, first_q, mack_q, oe_q;
    logic              start_w, stop_w, byte_end_w;

    assign start_w    = scl_i && sda_fall_i;
    assign stop_w     = scl_i && sda_rise_i;
    assign byte_end_w = scl_fall_i && (cnt_q == 4'd8);

    // Bus protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0;
            rw_q <= 1'b0; first_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0;
        end else if (start_w) begin
            st_q <= ST_ADDR; cnt_q <= '0; oe_q <= 1'b0;
        end else if (stop_w) begin
            st_q <= ST_IDLE; oe_q <= 1'b0;
        end else begin
            case (st_q)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        sh_q  <= {sh_q[6:0], sda_i};
                        cnt_q <= cnt_q + 4'd1;
                    end else if (byte_end_w) begin
                        if (sh_q[7:1] == {I2C_ADDR_HI, ad0_i}) begin
                            oe_q <= 1'b1; rw_q <= sh_q[0]; first_q <= 1'b1;
                            st_q <= ST_AACK;
                        end else begin
                            st_q <= ST_SKIP;
                        end
                    end
                end
                ST_AACK: if (scl_fall_i) begin
                    cnt_q <= '0;
                    if (rw_q) begin
                        sh_q <= rd_byte_i; oe_q <= ~rd_byte_i[7]; st_q <= ST_RD;
                    end else begin
                        oe_q <= 1'b0; st_q <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (scl_rise_i) begin
                        sh_q  <= {sh_q[6:0], sda_i};
                        cnt_q <= cnt_q + 4'd1;
                    end else if (byte_end_w) begin
                        oe_q <= 1'b1; first_q <= 1'b0; st_q <= ST_WACK;
                    end
                end
                ST_WACK: if (scl_fall_i) begin
                    oe_q <= 1'b0; cnt_q <= '0; st_q <= ST_WR;
                end
                ST_RD: begin
                    if (scl_rise_i) begin
                        cnt_q <= cnt_q + 4'd1;
                    end else if (byte_end_w) begin
                        oe_q <= 1'b0; st_q <= ST_RACK;
                    end else if (scl_fall_i) begin
                        sh_q <= {sh_q[6:0], 1'b0}; oe_q <= ~sh_q[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        mack_q <= ~sda_i;
                    end else if (scl_fall_i) begin
                        if (mack_q) begin
                            sh_q <= rd_byte_i; oe_q <= ~rd_byte_i[7];
                            cnt_q <= '0; st_q <= ST_RD;
                        end else begin
                            st_q <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o  = oe_q;
    assign wr_byte_o = sh_q;
    assign ptr_we_o  = (st_q == ST_WR) && byte_end_w && first_q;
    assign data_we_o = (st_q == ST_WR) && byte_end_w && !first_q;
    assign rd_adv_o  = (st_q == ST_RD) && byte_end_w;

    // R2
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !scl_i);
endmodule

// File: rtl/ctlport_spi.sv
// Write-only SPI-style target. Shifts the data line in on rising clock
// edges while the chip select is low. After an address byte equal to
// 0x20, it issues the pointer strobe and then one data strobe per byte.
module ctlport_spi
    import ctlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cs_i,
    input  logic              sclk_rise_i,
    input  logic              din_i,
    output logic              ptr_we_o,
    output logic              data_we_o,
    output logic [BYTE_W-1:0] wr_byte_o
);
    logic [BYTE_W-1:0] sh_q;
    logic [2:0]        cnt_q;
    logic [1:0]        nbyte_q;
    logic              ok_q, done_q;

    // Shift bits and count the bytes of one chip-select frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || cs_i) begin
            sh_q <= '0; cnt_q <= '0; nbyte_q <= '0; ok_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sclk_rise_i) begin
                sh_q   <= {sh_q[6:0], din_i};
                cnt_q  <= cnt_q + 3'd1;
                done_q <= (cnt_q == 3'd7);
            end
            if (done_q) begin
                if (nbyte_q == 2'd0) ok_q <= (sh_q == SPI_ADDR_BYTE);
                if (nbyte_q != 2'd2) nbyte_q <= nbyte_q + 2'd1;
            end
        end
    end

    assign wr_byte_o = sh_q;
    assign ptr_we_o  = done_q && ok_q && (nbyte_q == 2'd1);
    assign data_we_o = done_q && ok_q && (nbyte_q == 2'd2);

    // R9
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_i |=> !(ptr_we_o || data_we_o));
endmodule

// File: rtl/cfgport_top.sv
// Dual-mode configuration port: an I2C target with read and write, or a
// write-only SPI-style target, over one shared register bank. The first
// falling edge of sel_i after reset switches to SPI mode until reset.
// Assumes every serial pin stays stable for at least four clk periods.
module cfgport_top
    import ctlport_pkg::*;
#(
    parameter int unsigned NREG        = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   sel_i,
    output logic                   sda_oe_o,
    output logic                   spi_mode_o,
    output logic [NREG*BYTE_W-1:0] cfg_o
);
    // Bit order of the synchronized bundle: {sel, sda, scl}.
    logic [2:0] lvl_w, dly_w;
    logic       spi_mode_q;
    logic       i_ptr_we, i_data_we, i_rd_adv, s_ptr_we, s_data_we;
    logic [BYTE_W-1:0] i_byte, s_byte, rd_byte;
    logic       ptr_we, data_we;
    logic [BYTE_W-1:0] wr_byte;

    ctlport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({sel_i, sda_i, scl_i}),
        .lvl_o(lvl_w), .dly_o(dly_w)
    );

    // Latch SPI mode on the first falling edge of the shared pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                       spi_mode_q <= 1'b0;
        else if (dly_w[2] && !lvl_w[2])   spi_mode_q <= 1'b1;
    end

    ctlport_i2c u_i2c (
        .clk(clk), .rst_n(rst_n), .en_i(!spi_mode_q),
        .scl_i(lvl_w[0]), .scl_rise_i(lvl_w[0] && !dly_w[0]), .scl_fall_i(!lvl_w[0] && dly_w[0]),
        .sda_i(lvl_w[1]), .sda_rise_i(lvl_w[1] && !dly_w[1]), .sda_fall_i(!lvl_w[1] && dly_w[1]),
        .ad0_i(lvl_w[2]), .rd_byte_i(rd_byte), .sda_oe_o(sda_oe_o),
        .ptr_we_o(i_ptr_we), .data_we_o(i_data_we), .rd_adv_o(i_rd_adv), .wr_byte_o(i_byte)
    );

    ctlport_spi u_spi (
        .clk(clk), .rst_n(rst_n), .en_i(spi_mode_q), .cs_i(lvl_w[2]),
        .sclk_rise_i(lvl_w[0] && !dly_w[0]), .din_i(lvl_w[1]),
        .ptr_we_o(s_ptr_we), .data_we_o(s_data_we), .wr_byte_o(s_byte)
    );

    assign ptr_we  = spi_mode_q ? s_ptr_we  : i_ptr_we;
    assign data_we = spi_mode_q ? s_data_we : i_data_we;
    assign wr_byte = spi_mode_q ? s_byte    : i_byte;

    ctlport_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .ptr_we_i(ptr_we), .data_we_i(data_we),
        .rd_adv_i(i_rd_adv && !spi_mode_q), .wr_byte_i(wr_byte),
        .rd_byte_o(rd_byte), .bank_o(cfg_o)
    );

    assign spi_mode_o = spi_mode_q;

    // R8
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode_q |=> spi_mode_q);

    // R10
    spi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode_q |=> !sda_oe_o);
endmodule

// File: tb/sim_cfgport_top.sv
module sim_cfgport_top;
    localparam int CLK_NS = 10;
    localparam int Q      = 6;
    localparam logic [6:0] DEV = 7'b0010001;   // shared pin held high
    // Single-write vectors {pointer byte, data byte}
    localparam logic [15:0] VEC [6] = '{16'h005C, 16'h79E1, 16'h043F,
                                        16'h05AA, 16'h0777, 16'h7A92};

    logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1, m_sel = 1;
    logic sda_oe, spi_mode, sda_line;
    logic [39:0] cfg;
    int n_chk = 0, n_err = 0;
    logic [7:0] exp_reg [8];

    always #(CLK_NS/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    cfgport_top u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                    .sel_i(m_sel), .sda_oe_o(sda_oe), .spi_mode_o(spi_mode), .cfg_o(cfg));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int k = 0; k < 5; k++) chk(req, cfg[k*8 +: 8], exp_reg[k]);
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic i2c_start();
        m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
    endtask
    task automatic i2c_stop();
        m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq();
    endtask
    task automatic i2c_bit(input logic b, output logic got);
        m_sda = b; wq(); m_scl = 1; wq(); got = sda_line; wq(); m_scl = 0; wq();
    endtask
    task automatic i2c_wbyte(input logic [7:0] v, output logic ack);
        logic g;
        for (int i = 7; i >= 0; i--) i2c_bit(v[i], g);
        i2c_bit(1'b1, g);
        ack = !g;
    endtask
    task automatic i2c_rbyte(input logic give_ack, output logic [7:0] v);
        logic g;
        for (int i = 7; i >= 0; i--) begin i2c_bit(1'b1, g); v[i] = g; end
        i2c_bit(!give_ack, g);
    endtask

    // Write n bytes (first byte = pointer) packed MSB-first in b.
    task automatic i2c_wr(input logic [6:0] dev, input int n, input logic [31:0] b,
                          output logic aack, output logic all_ack);
        logic a;
        i2c_start(); i2c_wbyte({dev, 1'b0}, a); aack = a; all_ack = a;
        for (int i = 0; i < n; i++) begin i2c_wbyte(b[31-8*i -: 8], a); all_ack &= a; end
        i2c_stop();
    endtask

    // Optionally set the pointer, then read n bytes packed MSB-first.
    task automatic i2c_rd(input logic set_ptr, input logic [7:0] ptr, input int n,
                          output logic [23:0] got);
        logic a; logic [7:0] v;
        got = '0;
        if (set_ptr) begin
            i2c_start(); i2c_wbyte({DEV, 1'b0}, a); i2c_wbyte(ptr, a);
        end
        i2c_start(); i2c_wbyte({DEV, 1'b1}, a);
        for (int i = 0; i < n; i++) begin i2c_rbyte(i != n-1, v); got[23-8*i -: 8] = v; end
        i2c_stop();
    endtask

    task automatic spi_xfer(input int n, input logic [31:0] b);
        m_sel = 0; wq();
        for (int i = 0; i < n; i++)
            for (int j = 7; j >= 0; j--) begin
                m_scl = 0; m_sda = b[31-8*i-(7-j)]; wq(); m_scl = 1; wq();
            end
        wq(); m_sel = 1; wq(); wq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic aa, al; logic [23:0] got; logic [7:0] pb, db;
        exp_reg = '{8'h00, 8'h83, 8'h49, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        repeat (5) @(negedge clk); rst_n = 1; wq();

        // R1 reset state, R11 layout
        chk_bank("R1 R11 reset bank");
        chk("R1 mode", {7'b0, spi_mode}, 8'h00);
        chk("R1 sda released", {7'b0, sda_oe}, 8'h00);

        // R6 read before any pointer write uses index 0
        i2c_rd(1'b0, 8'h00, 1, got);
        chk("R6 default pointer read", got[23:16], 8'h00);
        // R4 pointer-only write, then R5 no increment over two reads
        i2c_wr(DEV, 1, 32'h01000000, aa, al);
        chk("R2 addr ack", {7'b0, aa}, 8'h01);
        i2c_rd(1'b0, 8'h00, 2, got);
        chk("R6 current pointer byte0", got[23:16], 8'h83);
        chk("R5 fixed pointer byte1", got[15:8], 8'h83);

        // Table walk: single writes then read-back (R2 R4 R6 R7)
        for (int v = 0; v < 6; v++) begin
            pb = VEC[v][15:8]; db = VEC[v][7:0];
            i2c_wr(DEV, 2, {pb, db, 16'h0}, aa, al);
            chk("R2 write acks", {7'b0, al}, 8'h01);
            if (pb[2:0] < 3'd5) exp_reg[pb[2:0]] = db;
            chk_bank("R4 R7 single write");
            i2c_rd(1'b1, pb, 1, got);
            chk("R6 R7 readback", got[23:16], (pb[2:0] < 3'd5) ? db : 8'h00);
        end

        // R5 block write with increment
        i2c_wr(DEV, 4, 32'h81A1A2A3, aa, al);
        exp_reg[1] = 8'hA1; exp_reg[2] = 8'hA2; exp_reg[3] = 8'hA3;
        chk_bank("R5 block write");
        // R5 R6 block read
        i2c_rd(1'b1, 8'h81, 3, got);
        chk("R6 block read 0", got[23:16], 8'hA1);
        chk("R6 block read 1", got[15:8], 8'hA2);
        chk("R5 block read 2", got[7:0], 8'hA3);
        // R5 increment clear: both bytes land on index 2
        i2c_wr(DEV, 3, 32'h02112200, aa, al);
        exp_reg[2] = 8'h22;
        chk_bank("R5 pointer hold");
        // R5 wrap from index 7 to 0, R7 discard at 7
        i2c_wr(DEV, 3, 32'h87556600, aa, al);
        exp_reg[0] = 8'h66;
        chk_bank("R5 R7 wrap");

        // R3 wrong address bit and wrong upper bits
        i2c_wr(7'b0010000, 2, 32'h00EE0000, aa, al);
        chk("R3 nack low bit", {7'b0, aa}, 8'h00);
        i2c_wr(7'b1010001, 2, 32'h00EE0000, aa, al);
        chk("R3 nack high bits", {7'b0, aa}, 8'h00);
        chk_bank("R3 ignored");

        // R8 switch to SPI, R9 block write
        spi_xfer(4, 32'h2083C3C4);
        chk("R8 spi mode", {7'b0, spi_mode}, 8'h01);
        exp_reg[3] = 8'hC3; exp_reg[4] = 8'hC4;
        chk_bank("R9 spi block write");
        spi_xfer(4, 32'h20015A5B);
        exp_reg[1] = 8'h5B;
        chk_bank("R9 spi single write");
        spi_xfer(3, 32'h22009900);
        chk_bank("R9 spi wrong address");

        // R10 I2C traffic ignored, R8 stays in SPI
        i2c_wr(DEV, 2, 32'h00120000, aa, al);
        chk("R10 no ack", {7'b0, aa}, 8'h00);
        chk_bank("R10 bank unchanged");
        chk("R8 sticky", {7'b0, spi_mode}, 8'h01);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule